// File: doc/BRIEF.md
# Pipelined Synchronous Byte-Write SRAM

This block is a single-clock static RAM with a registered front end and a registered read path. Every synchronous input is sampled on the rising clock edge: the word address, the write data, three chip selects and the write controls. The 32-bit word is split into four 8-bit lanes. A write needs no external strobe. It is carried out on the edge that follows the capture edge, using the values held in the input registers.

The width of each write is chosen in two levels. A global write input, when low, stores the whole word whatever the other controls say. When it is high, a lane-write enable decides whether the four per-lane selects are honoured. When both the global write input and the lane-write enable are high, the cycle is a read. Read data goes through an output pipeline register. The shared data pins are modelled as a separate input bus, an output bus and a drive-enable flag. The three chip selects let several instances share one address space for depth expansion.

Top module: `sync_bw_sram`

## Requirements
- R1: Address, write data, chip selects and write controls take effect only through their values at a rising clock edge. Changes between edges have no effect on the stored contents.
- R2: The device is selected only when `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0 at the capture edge.
- R3: A deselected cycle writes nothing and does not turn on the output drivers.
- R4: A selected read captured at edge N puts the stored word on `dout_o`, with `dq_oe_o` set, after edge N+1.
- R5: When `all_wr_n`=1 and `lane_wr_en_n`=0, each bit `lane_sel_n[i]`=0 writes lane i, which is `din_i[8*i+7:8*i]`. So bit 0 selects bits 7:0 and bit 3 selects bits 31:24. Any mix of one to four lanes is allowed, and lanes that are not selected keep their old contents.
- R6: `all_wr_n`=0 writes all four lanes, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R7: A cycle with `all_wr_n`=1 and `lane_wr_en_n`=1 is a read, and `lane_sel_n` has no effect on it.
- R8: `dq_oe_o` is 0 after the output edge of any write cycle. This includes a lane-write with no lane selected.
- R9: `out_en_n`=1 forces `dq_oe_o` to 0 at once, without waiting for a clock edge.
- R10: A read captured on the edge right after a write to the same address returns the newly written data.
- R11: After reset, `dq_oe_o` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control registers |
| addr_i | input | ADDR_W | Word address |
| din_i | input | 32 | Write data, the input side of the shared data pins |
| dout_o | output | 32 | Read data from the output pipeline register |
| dq_oe_o | output | 1 | Data pins driven when 1 |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |

## Verification
The results of a write become visible one edge after the capture edge, so the bench checks every write with a later read. The data of a read is due after the second rising edge that follows its setup. The bench drives inputs on the falling edge and samples on the falling edge after that second rising edge. It never samples earlier. For the back-to-back case, the read is set up on the falling edge right after the write's capture edge, which checks that the update lands in time. The output enable is the one result with no clock latency, so it is sampled within the same low phase in which `out_en_n` is changed.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [LANES-1:0] lane_mask_t;

  // Selected only for the pattern low / high / low.
  function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
    return !a_n && b && !c_n;
  endfunction

  // Two-level write width: global write wins, else lane enable gates per-lane selects.
  function automatic lane_mask_t write_lanes(input logic all_n, input logic lane_en_n,
                                             input lane_mask_t sel_n);
    if (!all_n)          return '1;
    else if (!lane_en_n) return ~sel_n;
    else                 return '0;
  endfunction

  function automatic logic is_write_cycle(input logic all_n, input logic lane_en_n);
    return !all_n || !lane_en_n;
  endfunction

  // Merge new lanes into an old word.
  function automatic logic [WORD_W-1:0] merge_lanes(input logic [WORD_W-1:0] old_w,
                                                    input logic [WORD_W-1:0] new_w,
                                                    input lane_mask_t m);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (m[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  lane_mask_t        lane_sel_n,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] din_q,
  output lane_mask_t        wr_mask_q,
  output logic              rd_req_q,
  output logic              sel_q
);
  logic       sel_d;
  lane_mask_t mask_d;
  logic       wr_cyc_d;

  assign sel_d    = chip_selected(sel_a_n, sel_b, sel_c_n);
  assign wr_cyc_d = is_write_cycle(all_wr_n, lane_wr_en_n);
  assign mask_d   = sel_d ? write_lanes(all_wr_n, lane_wr_en_n, lane_sel_n) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      wr_mask_q <= '0;
      rd_req_q  <= 1'b0;
    end else begin
      sel_q     <= sel_d;
      wr_mask_q <= mask_d;
      rd_req_q  <= sel_d && !wr_cyc_d;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_i;
    din_q  <= din_i;
  end

  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> (wr_mask_q == '0) && !rd_req_q); // R3
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_q |-> (wr_mask_q == '0)); // R7
endmodule

// File: rtl/sram_core.sv
module sram_core
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [WORD_W-1:0] din_q,
  input  lane_mask_t        wr_mask_q,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] lane_mem [LANES][DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_mask_q[g]) lane_mem[g][addr_q] <= din_q[g*LANE_W +: LANE_W];
    end
    assign rd_word[g*LANE_W +: LANE_W] = lane_mem[g][addr_q];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_q,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              out_en_n,
  output logic [WORD_W-1:0] dout_o,
  output logic              dq_oe_o
);
  logic rd_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld_q <= 1'b0;
    else        rd_vld_q <= rd_req_q;
  end

  always_ff @(posedge clk) begin
    if (rd_req_q) dout_o <= rd_word;
  end

  assign dq_oe_o = rd_vld_q && !out_en_n;

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> $past(rd_req_q)); // R8
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_q |=> rd_vld_q); // R4
  always_comb begin
    if (rst_n && out_en_n) AST_OE_ASYNC: assert (!dq_oe_o); // R9
  end
endmodule

// File: rtl/sync_bw_sram.sv
module sync_bw_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       din_i,
  output logic [31:0]       dout_o,
  output logic              dq_oe_o,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [3:0]        lane_sel_n,
  input  logic              out_en_n
);
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] din_q;
  lane_mask_t        wr_mask_q;
  logic              rd_req_q;
  logic              sel_q;
  logic [WORD_W-1:0] rd_word;
  logic              all_wr_q;

  sram_in_stage #(.ADDR_W(ADDR_W)) u_in (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .din_i(din_i),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .addr_q(addr_q), .din_q(din_q), .wr_mask_q(wr_mask_q),
    .rd_req_q(rd_req_q), .sel_q(sel_q)
  );

  sram_core #(.ADDR_W(ADDR_W)) u_core (
    .clk(clk), .addr_q(addr_q), .din_q(din_q), .wr_mask_q(wr_mask_q),
    .rd_word(rd_word)
  );

  sram_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .rd_req_q(rd_req_q), .rd_word(rd_word),
    .out_en_n(out_en_n), .dout_o(dout_o), .dq_oe_o(dq_oe_o)
  );

  // Registered global-write flag, kept only for the check below.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) all_wr_q <= 1'b0;
    else        all_wr_q <= !all_wr_n && chip_selected(sel_a_n, sel_b, sel_c_n);
  end

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    all_wr_q |-> (wr_mask_q == '1) && sel_q); // R6
  AST_WRITE_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask_q != '0) |=> !dq_oe_o); // R8
endmodule

// File: tb/sync_bw_sram_bench.sv
module sync_bw_sram_bench;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   din_i = '0;
  logic [31:0]   dout_o;
  logic          dq_oe_o;
  logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic          all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
  logic [3:0]    lane_sel_n = 4'hF;
  logic          out_en_n = 1'b0;

  int checks = 0, fails = 0;
  logic [31:0] ref_mem [1 << AW];

  always #5 clk = ~clk;

  sync_bw_sram #(.ADDR_W(AW)) u_sync_bw_sram (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
    all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF;
  endtask

  // Called at a falling edge; returns at the falling edge after the capture edge.
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic g_n,
                    input logic le_n, input logic [3:0] ls_n, input logic [2:0] cs);
    addr_i = a; din_i = d; all_wr_n = g_n; lane_wr_en_n = le_n; lane_sel_n = ls_n;
    {sel_a_n, sel_b, sel_c_n} = cs;
    @(posedge clk);
    if (cs == 3'b010) begin
      for (int i = 0; i < 4; i++)
        if (!g_n || (!le_n && !ls_n[i])) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
    end
    @(negedge clk);
    addr_i = ~a; din_i = ~d; // R1: changes between edges with the device idle
    idle();
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [3:0] ls_n);
    addr_i = a; all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = ls_n;
    {sel_a_n, sel_b, sel_c_n} = 3'b010;
    @(posedge clk); @(negedge clk);
    idle();
    @(posedge clk); @(negedge clk);
    chk({req, " oe"}, {31'd0, dq_oe_o}, 32'd1);
    chk(req, dout_o, ref_mem[a]);
  endtask

  task automatic t_reset();
    chk("R11 oe after reset", {31'd0, dq_oe_o}, 32'd0);
  endtask

  task automatic t_lanes();
    wr(10'd5, 32'h11223344, 1'b0, 1'b1, 4'hF, 3'b010);
    rd_chk("R6 full word", 10'd5, 4'hF);
    wr(10'd5, 32'hAAAAAAAA, 1'b1, 1'b0, 4'b1110, 3'b010);
    rd_chk("R5 lane 0", 10'd5, 4'hF);
    wr(10'd5, 32'hBBBBBBBB, 1'b1, 1'b0, 4'b0111, 3'b010);
    rd_chk("R5 lane 3", 10'd5, 4'hF);
    wr(10'd5, 32'hCCCCCCCC, 1'b1, 1'b0, 4'b1001, 3'b010);
    rd_chk("R5 lanes 1 and 2", 10'd5, 4'hF);
    wr(10'd6, 32'h01020304, 1'b0, 1'b1, 4'hF, 3'b010);
    wr(10'd6, 32'hDEADBEEF, 1'b1, 1'b0, 4'b0000, 3'b010);
    rd_chk("R5 all four lanes", 10'd6, 4'hF);
  endtask

  task automatic t_global();
    wr(10'd7, 32'h0, 1'b0, 1'b1, 4'hF, 3'b010);
    wr(10'd7, 32'h5A5A1234, 1'b0, 1'b0, 4'b1111, 3'b010);
    rd_chk("R6 global over empty lane select", 10'd7, 4'hF);
    wr(10'd7, 32'h87654321, 1'b0, 1'b0, 4'b1110, 3'b010);
    rd_chk("R6 global over one-lane select", 10'd7, 4'hF);
  endtask

  task automatic t_select();
    wr(10'd8, 32'hCAFEF00D, 1'b0, 1'b1, 4'hF, 3'b010);
    wr(10'd8, 32'h0, 1'b0, 1'b1, 4'hF, 3'b110);
    wr(10'd8, 32'h0, 1'b0, 1'b1, 4'hF, 3'b000);
    wr(10'd8, 32'h0, 1'b0, 1'b1, 4'hF, 3'b011);
    rd_chk("R2 R3 deselected writes dropped", 10'd8, 4'hF);
    addr_i = 10'd8; {sel_a_n, sel_b, sel_c_n} = 3'b011;
    @(posedge clk); @(negedge clk); idle();
    @(posedge clk); @(negedge clk);
    chk("R3 deselected read oe", {31'd0, dq_oe_o}, 32'd0);
  endtask

  task automatic t_read_ignores_lanes();
    rd_chk("R7 read with lane selects low", 10'd8, 4'b0000);
    rd_chk("R7 contents unchanged", 10'd8, 4'hF);
  endtask

  task automatic t_write_oe();
    wr(10'd9, 32'h13579BDF, 1'b1, 1'b0, 4'hF, 3'b010);
    @(posedge clk); @(negedge clk);
    chk("R8 oe after empty lane write", {31'd0, dq_oe_o}, 32'd0);
    wr(10'd9, 32'h2468ACE0, 1'b0, 1'b1, 4'hF, 3'b010);
    @(posedge clk); @(negedge clk);
    chk("R8 oe after write", {31'd0, dq_oe_o}, 32'd0);
  endtask

  task automatic t_oe_async();
    addr_i = 10'd5; {sel_a_n, sel_b, sel_c_n} = 3'b010;
    @(posedge clk); @(negedge clk); idle();
    @(posedge clk); @(negedge clk);
    out_en_n = 1'b1; #1;
    chk("R9 oe forced off", {31'd0, dq_oe_o}, 32'd0);
    out_en_n = 1'b0; #1;
    chk("R9 oe restored", {31'd0, dq_oe_o}, 32'd1);
    @(negedge clk);
  endtask

  task automatic t_back_to_back();
    addr_i = 10'd12; din_i = 32'h0BADC0DE; all_wr_n = 1'b0;
    {sel_a_n, sel_b, sel_c_n} = 3'b010;
    @(posedge clk); ref_mem[12] = 32'h0BADC0DE; @(negedge clk);
    all_wr_n = 1'b1; din_i = 32'h0;
    @(posedge clk); @(negedge clk); idle();
    @(posedge clk); @(negedge clk);
    chk("R10 read right after write", dout_o, 32'h0BADC0DE);
    chk("R10 oe", {31'd0, dq_oe_o}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_lanes();
    t_global();
    t_select();
    t_read_ignores_lanes();
    t_write_oe();
    t_oe_async();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule